// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a parameterised number of external interrupt lines and presents one interrupt request to a single processor. Each line can be set to trigger on an edge or on a level, with either polarity, and can be masked, routed away from the processor and given a 4-bit priority and a vector number. The controller compares the best waiting request against the processor's task priority and against the interrupts already being serviced, and raises its output only when the request outranks both.

Software reaches the block through a simple 32-bit register port with one-cycle write strobes and combinational read data. Reading the acknowledge register hands over a vector and moves that source into service. Writing the end-of-interrupt register retires the most important interrupt in service. A programmable spurious vector is returned when nothing qualifies. A self-clearing reset bit reinitialises the whole controller. Word offsets used below are byte addresses on `bus_addr`. Source register pairs start at 0x100, eight bytes apart: the vector/priority word of source i sits at 0x100+8*i and its routing word at 0x104+8*i.

Top module: `vpic_top`

## Requirements
- R1: After reset, `irq_out` is 0, the task priority register (0x00C) reads 15, the spurious register (0x008) reads the SPUR_RST parameter, every vector/priority word reads 0x80000000 (mask bit 31 set, all else 0), every routing word reads 0 and the configuration word (0x000) reads 0.
- R2: In the vector/priority word, bit 22 selects edge (0) or level (1) and bit 23 selects falling edge or low level (0) versus rising edge or high level (1). An edge is latched as pending until acknowledged; a level is pending only while the line is at its active level.
- R3: A source whose mask bit 31 is 1 is neither signalled on `irq_out` nor handed out by an acknowledge, though its pending state is kept.
- R4: `irq_out` is 1 only when the best eligible priority (bits 19:16) is strictly greater than both the task priority (0x00C, bits 3:0) and the highest priority in service; a task priority of 15 blocks every source.
- R5: A read of the acknowledge register (0x010) while `irq_out` is 1 returns the vector (bits VEC_W-1:0) of the highest-priority eligible source, the lowest source number winning ties; that source enters service and a latched edge is consumed.
- R6: A read of the acknowledge register while `irq_out` is 0 returns the spurious vector programmed at 0x008 and changes no state.
- R7: A write of any value to the end-of-interrupt register (0x014) takes the highest-priority in-service source (lowest number on a tie) out of service.
- R8: Bit 30 of the vector/priority word reads 1 while the source is pending or in service; while it is 1, a write changes only the mask bit and leaves sense, polarity, priority and vector unchanged.
- R9: Writing 1 to bit 31 of the configuration word (0x000) reinitialises all controller state to the R1 values on the next clock, after which the bit reads 0.
- R10: The feature word (0x004) reads the version code in bits 7:0, the last source number (NUM_SRC-1) in bits 15:8 and the last processor number (0) in bits 23:16.
- R11: A source whose routing word bit 0 is 0 is neither signalled nor acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | NUM_SRC | External interrupt lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (acknowledge side effect) |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with six sources, an 8-bit vector, version code 3 and an all-ones spurious reset value. Six sources give a source count that is not a power of two, so the index decoder sees unused slots, and leave room for three sources racing at once with two of them tied in priority. Version 3 and the odd count make every field of the feature word distinct from its default, and the all-ones spurious value differs from the one the bench later programs, so both the reset and the programmed spurious path are visible.

// File: rtl/vpic_pkg.sv
// Package: register offsets and field positions shared by the controller.
// Assumes a 12-bit byte address and 32-bit data words.
package vpic_pkg;
    localparam int BUS_ADDR_W  = 12;
    localparam int PRI_W       = 4;

    localparam logic [BUS_ADDR_W-1:0] OFS_GCFG = 12'h000;
    localparam logic [BUS_ADDR_W-1:0] OFS_FEAT = 12'h004;
    localparam logic [BUS_ADDR_W-1:0] OFS_SPUR = 12'h008;
    localparam logic [BUS_ADDR_W-1:0] OFS_TPR  = 12'h00C;
    localparam logic [BUS_ADDR_W-1:0] OFS_IACK = 12'h010;
    localparam logic [BUS_ADDR_W-1:0] OFS_EOI  = 12'h014;
    localparam logic [3:0]            SRC_PAGE = 4'h1;

    localparam int VP_MASK_BIT  = 31;
    localparam int VP_ACT_BIT   = 30;
    localparam int VP_POL_BIT   = 23;
    localparam int VP_SENSE_BIT = 22;
    localparam int VP_PRI_LSB   = 16;
    localparam int GCFG_RST_BIT = 31;
endpackage

// File: rtl/vpic_source.sv
// Module: one interrupt source. Samples its line, detects edge or level,
// holds its configuration, pending and in-service state.
// Assumes irq_in is synchronous to clk; rst_n already merges soft reset.
module vpic_source #(
    parameter int VEC_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      irq_in,
    input  logic                      vp_we,
    input  logic                      dest_we,
    input  logic [31:0]               wdata,
    input  logic                      take,
    input  logic                      retire,
    output logic                      eligible,
    output logic                      in_svc,
    output logic                      mask_o,
    output logic                      dest_o,
    output logic [vpic_pkg::PRI_W-1:0] pri_o,
    output logic [VEC_W-1:0]          vec_o,
    output logic [31:0]               vp_rd,
    output logic [31:0]               dest_rd
);
    import vpic_pkg::*;

    logic             samp_q, prev_q, edge_pend, isr_q;
    logic             mask_q, pol_q, sense_q, dest_q;
    logic [PRI_W-1:0] pri_q;
    logic [VEC_W-1:0] vec_q;
    logic             edge_hit, lvl_act, pending, activity;

    assign edge_hit = pol_q ? (samp_q & ~prev_q) : (~samp_q & prev_q);
    assign lvl_act  = (samp_q == pol_q);
    assign pending  = sense_q ? lvl_act : edge_pend;
    assign activity = pending | isr_q;
    assign eligible = pending & ~mask_q & dest_q & ~isr_q;
    assign in_svc   = isr_q;
    assign mask_o   = mask_q;
    assign dest_o   = dest_q;
    assign pri_o    = pri_q;
    assign vec_o    = vec_q;

    // Read-back images of the two per-source words.
    always_comb begin
        vp_rd = 32'(vec_q);
        vp_rd[VP_PRI_LSB +: PRI_W] = pri_q;
        vp_rd[VP_SENSE_BIT]        = sense_q;
        vp_rd[VP_POL_BIT]          = pol_q;
        vp_rd[VP_ACT_BIT]          = activity;
        vp_rd[VP_MASK_BIT]         = mask_q;
        dest_rd = {31'b0, dest_q};
    end

    // Line sampler: current and previous sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            samp_q <= irq_in;
            prev_q <= samp_q;
        end
    end

    // Edge latch: a new edge wins over a same-cycle acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || sense_q) edge_pend <= 1'b0;
        else                   edge_pend <= (edge_pend & ~take) | edge_hit;
    end

    // In-service flag: set by acknowledge, cleared by end-of-interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)      isr_q <= 1'b0;
        else if (retire) isr_q <= 1'b0;
        else if (take)   isr_q <= 1'b1;
    end

    // Configuration: mask always writable, other fields only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= 1'b1;
            pol_q   <= 1'b0;
            sense_q <= 1'b0;
            pri_q   <= '0;
            vec_q   <= '0;
            dest_q  <= 1'b0;
        end else begin
            if (vp_we) begin
                mask_q <= wdata[VP_MASK_BIT];
                if (!activity) begin
                    pol_q   <= wdata[VP_POL_BIT];
                    sense_q <= wdata[VP_SENSE_BIT];
                    pri_q   <= wdata[VP_PRI_LSB +: PRI_W];
                    vec_q   <= wdata[VEC_W-1:0];
                end
            end
            if (dest_we) dest_q <= wdata[0];
        end
    end

    // R8: a write during activity leaves the locked fields untouched.
    assert_vp_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vp_we && activity) |=> (pri_q == $past(pri_q) && vec_q == $past(vec_q)
                                 && sense_q == $past(sense_q) && pol_q == $past(pol_q)));

    // R5: an acknowledged edge is consumed unless a fresh edge arrives.
    assert_edge_consumed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !sense_q && !edge_hit) |=> !edge_pend);
endmodule

// File: rtl/vpic_pick.sv
// Module: picks the highest-priority requester; lowest index wins ties.
// Assumes priority 0 still counts as a request (best_pri then reads 0).
module vpic_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]                       req,
    input  logic [N-1:0][vpic_pkg::PRI_W-1:0]  pri,
    output logic                               found,
    output logic [IDX_W-1:0]                   idx,
    output logic [vpic_pkg::PRI_W-1:0]         best_pri
);
    // Linear scan; strict compare keeps the lower index on a tie.
    always_comb begin
        found    = 1'b0;
        idx      = '0;
        best_pri = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!found || pri[i] > best_pri)) begin
                found    = 1'b1;
                idx      = IDX_W'(i);
                best_pri = pri[i];
            end
        end
    end
endmodule

// File: rtl/vpic_top.sv
// Module: vectored priority interrupt controller for one processor.
// Holds global registers, decodes the register port, arbitrates pending
// and in-service sources, and drives the single interrupt output.
// Assumes NUM_SRC <= 32 and VEC_W <= 16.
module vpic_top #(
    parameter int          NUM_SRC  = 8,
    parameter int          VEC_W    = 8,
    parameter int          VERSION  = 2,
    parameter logic [VEC_W-1:0] SPUR_RST = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_out
);
    import vpic_pkg::*;

    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic                             soft_rst, core_rst_n;
    logic [PRI_W-1:0]                 tpr_q;
    logic [VEC_W-1:0]                 spur_q;
    logic [NUM_SRC-1:0]               elig, in_svc, src_mask, src_dest, take, retire;
    logic [NUM_SRC-1:0][PRI_W-1:0]    src_pri;
    logic [NUM_SRC-1:0][VEC_W-1:0]    src_vec;
    logic [NUM_SRC-1:0][31:0]         vp_rd, dest_rd;
    logic                             pend_found, svc_found, deliver, ack, eoi;
    logic [SRC_W-1:0]                 pend_idx, svc_idx;
    logic [PRI_W-1:0]                 pend_pri, svc_pri;
    logic                             src_hit;
    logic [4:0]                       src_sel;

    assign core_rst_n = rst_n & ~soft_rst;
    assign src_sel    = bus_addr[7:3];
    assign src_hit    = (bus_addr[11:8] == SRC_PAGE) && (int'(src_sel) < NUM_SRC);
    assign ack        = bus_rd && !src_hit && (bus_addr == OFS_IACK);
    assign eoi        = bus_wr && !src_hit && (bus_addr == OFS_EOI);
    assign deliver    = pend_found && (pend_pri > tpr_q) && (pend_pri > svc_pri);
    assign irq_out    = deliver;

    // Self-clearing soft reset request.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) soft_rst <= 1'b0;
        else soft_rst <= bus_wr && (bus_addr == OFS_GCFG) && bus_wdata[GCFG_RST_BIT];
    end

    // Processor task priority and spurious vector registers.
    always_ff @(posedge clk) begin
        if (!core_rst_n) begin
            tpr_q  <= '1;
            spur_q <= SPUR_RST;
        end else if (bus_wr) begin
            if (bus_addr == OFS_TPR)  tpr_q  <= bus_wdata[PRI_W-1:0];
            if (bus_addr == OFS_SPUR) spur_q <= bus_wdata[VEC_W-1:0];
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign take[i]   = ack && deliver && (pend_idx == SRC_W'(i));
        assign retire[i] = eoi && svc_found && (svc_idx == SRC_W'(i));

        vpic_source #(.VEC_W(VEC_W)) u_src (
            .clk      (clk),
            .rst_n    (core_rst_n),
            .irq_in   (irq_src[i]),
            .vp_we    (bus_wr && src_hit && (src_sel == 5'(i)) && !bus_addr[2]),
            .dest_we  (bus_wr && src_hit && (src_sel == 5'(i)) &&  bus_addr[2]),
            .wdata    (bus_wdata),
            .take     (take[i]),
            .retire   (retire[i]),
            .eligible (elig[i]),
            .in_svc   (in_svc[i]),
            .mask_o   (src_mask[i]),
            .dest_o   (src_dest[i]),
            .pri_o    (src_pri[i]),
            .vec_o    (src_vec[i]),
            .vp_rd    (vp_rd[i]),
            .dest_rd  (dest_rd[i])
        );
    end

    vpic_pick #(.N(NUM_SRC), .IDX_W(SRC_W)) u_pick_pend (
        .req(elig), .pri(src_pri), .found(pend_found), .idx(pend_idx), .best_pri(pend_pri)
    );

    vpic_pick #(.N(NUM_SRC), .IDX_W(SRC_W)) u_pick_svc (
        .req(in_svc), .pri(src_pri), .found(svc_found), .idx(svc_idx), .best_pri(svc_pri)
    );

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (src_hit) begin
            bus_rdata = bus_addr[2] ? dest_rd[src_sel] : vp_rd[src_sel];
        end else begin
            case (bus_addr)
                OFS_GCFG: bus_rdata = {soft_rst, 31'b0};
                OFS_FEAT: bus_rdata = {8'b0, 8'd0, 8'(NUM_SRC - 1), 8'(VERSION)};
                OFS_SPUR: bus_rdata = 32'(spur_q);
                OFS_TPR:  bus_rdata = 32'(tpr_q);
                OFS_IACK: bus_rdata = deliver ? 32'(src_vec[pend_idx]) : 32'(spur_q);
                default:  bus_rdata = '0;
            endcase
        end
    end

    assert_soft_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

    assert_ack_enters_service_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
        (ack && deliver) |=> in_svc[$past(pend_idx)]);

    assert_ack_unmasked_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
        (ack && deliver) |-> !src_mask[pend_idx]);

    assert_ack_routed_R11: assert property (@(posedge clk) disable iff (!core_rst_n)
        (ack && deliver) |-> src_dest[pend_idx]);

    assert_tpr_ceiling_R4: assert property (@(posedge clk) disable iff (!core_rst_n)
        (tpr_q == '1) |-> !irq_out);

    assert_eoi_retires_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
        (eoi && svc_found) |=> !in_svc[$past(svc_idx)]);
endmodule

// File: tb/test_vpic_top.sv
module test_vpic_top;
    localparam int NS = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NS-1:0] irq_src;
    logic          bus_wr, bus_rd;
    logic [11:0]   bus_addr;
    logic [31:0]   bus_wdata, bus_rdata;
    logic          irq_out;
    int            checks = 0;
    int            errors = 0;
    bit            done = 0;

    always #4 clk = ~clk;

    vpic_top #(.NUM_SRC(NS), .VEC_W(8), .VERSION(3), .SPUR_RST(8'hFF)) i_vpic_top (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    localparam logic [11:0] A_GCFG = 12'h000, A_FEAT = 12'h004, A_SPUR = 12'h008,
                            A_TPR = 12'h00C, A_IACK = 12'h010, A_EOI = 12'h014;

    function automatic logic [11:0] a_vp(int i);   return 12'(12'h100 + 8 * i); endfunction
    function automatic logic [11:0] a_dest(int i); return 12'(12'h104 + 8 * i); endfunction
    function automatic logic [31:0] vpw(bit m, bit lvl, bit pol, int pri, int vec);
        return {m, 7'b0, pol, lvl, 2'b0, 4'(pri), 8'b0, 8'(vec)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic waitc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rdchk(string req, logic [11:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic setup_src(int i, bit lvl, bit pol, int pri, int vec);
        wr(a_dest(i), 32'd1);
        wr(a_vp(i), vpw(0, lvl, pol, pri, vec));
    endtask

    task automatic t_reset;
        chk("R1 irq_out", 32'(irq_out), 0);
        rdchk("R1 gcfg", A_GCFG, 0);
        rdchk("R1 tpr", A_TPR, 32'hF);
        rdchk("R1 spur", A_SPUR, 32'hFF);
        rdchk("R1 vp0", a_vp(0), 32'h8000_0000);
        rdchk("R1 dest0", a_dest(0), 0);
        rdchk("R6 iack at reset", A_IACK, 32'hFF);
    endtask

    task automatic t_feature;
        rdchk("R10 feature", A_FEAT, 32'h0000_0503);
    endtask

    task automatic t_edge_rise;
        wr(A_TPR, 0);
        setup_src(0, 0, 1, 5, 8'h20);
        irq_src[0] = 1'b1;
        waitc(4);
        chk("R2 rising edge pending", 32'(irq_out), 1);
        rdchk("R8 activity on pending", a_vp(0), 32'h4085_0020);
        rdchk("R5 ack vector", A_IACK, 32'h20);
        chk("R5 in service blocks", 32'(irq_out), 0);
        rdchk("R8 activity in service", a_vp(0), 32'h4085_0020);
        irq_src[0] = 1'b0;
        wr(A_EOI, 0);
        waitc(2);
        rdchk("R8 activity cleared", a_vp(0), 32'h0085_0020);
        chk("R5 edge consumed", 32'(irq_out), 0);
    endtask

    task automatic t_edge_fall;
        setup_src(1, 0, 0, 3, 8'h21);
        irq_src[1] = 1'b1;
        waitc(4);
        chk("R2 rising ignored on falling", 32'(irq_out), 0);
        irq_src[1] = 1'b0;
        waitc(4);
        chk("R2 falling edge pending", 32'(irq_out), 1);
        rdchk("R5 ack falling", A_IACK, 32'h21);
        wr(A_EOI, 0);
        chk("R7 eoi idle", 32'(irq_out), 0);
    endtask

    task automatic t_level;
        setup_src(2, 1, 0, 4, 8'h22);
        waitc(3);
        chk("R2 inactive high level", 32'(irq_out), 0);
        irq_src[2] = 1'b0;
        waitc(3);
        chk("R2 active low level", 32'(irq_out), 1);
        rdchk("R5 ack level", A_IACK, 32'h22);
        chk("R5 level in service", 32'(irq_out), 0);
        wr(A_EOI, 0);
        chk("R2 level still asserted", 32'(irq_out), 1);
        irq_src[2] = 1'b1;
        waitc(3);
        chk("R2 level released", 32'(irq_out), 0);
        rdchk("R8 level idle word", a_vp(2), 32'h0044_0022);
    endtask

    task automatic t_arbitration;
        setup_src(3, 0, 1, 7, 8'h23);
        setup_src(4, 0, 1, 7, 8'h24);
        setup_src(5, 0, 1, 9, 8'h25);
        irq_src[5:3] = 3'b111;
        waitc(4);
        rdchk("R5 highest priority", A_IACK, 32'h25);
        chk("R4 lower than in service", 32'(irq_out), 0);
        wr(A_EOI, 0);
        chk("R7 eoi reopens", 32'(irq_out), 1);
        rdchk("R5 tie lowest index", A_IACK, 32'h23);
        chk("R4 equal to in service", 32'(irq_out), 0);
        rdchk("R6 spurious when blocked", A_IACK, 32'hFF);
        irq_src[5] = 1'b0;
        waitc(2);
        irq_src[5] = 1'b1;
        waitc(4);
        chk("R4 nesting above in service", 32'(irq_out), 1);
        rdchk("R5 nested ack", A_IACK, 32'h25);
        wr(A_EOI, 0);
        rdchk("R7 highest retired", a_vp(5), 32'h0089_0025);
        rdchk("R7 lower still in service", a_vp(3), 32'h4087_0023);
        chk("R4 tie still blocked", 32'(irq_out), 0);
        wr(A_EOI, 0);
        chk("R7 second eoi", 32'(irq_out), 1);
        rdchk("R5 remaining tie", A_IACK, 32'h24);
        wr(A_EOI, 0);
        chk("R7 all retired", 32'(irq_out), 0);
        irq_src[5:3] = 3'b000;
        waitc(3);
    endtask

    task automatic t_task_priority;
        irq_src[0] = 1'b1;
        waitc(4);
        wr(A_TPR, 5);
        chk("R4 equal to task priority", 32'(irq_out), 0);
        wr(A_TPR, 4);
        chk("R4 above task priority", 32'(irq_out), 1);
        wr(A_TPR, 15);
        chk("R4 task priority 15", 32'(irq_out), 0);
        rdchk("R6 spurious under tpr", A_IACK, 32'hFF);
        wr(A_TPR, 0);
        chk("R6 spurious read kept pending", 32'(irq_out), 1);
    endtask

    task automatic t_mask;
        wr(a_vp(0), vpw(1, 0, 1, 5, 8'h20));
        chk("R3 masked", 32'(irq_out), 0);
        rdchk("R3 masked ack spurious", A_IACK, 32'hFF);
        wr(a_vp(0), vpw(0, 0, 1, 5, 8'h20));
        chk("R3 pending kept under mask", 32'(irq_out), 1);
    endtask

    task automatic t_dest;
        wr(a_dest(0), 0);
        chk("R11 unrouted", 32'(irq_out), 0);
        rdchk("R11 unrouted ack spurious", A_IACK, 32'hFF);
        wr(a_dest(0), 1);
        chk("R11 routed again", 32'(irq_out), 1);
    endtask

    task automatic t_lock;
        wr(a_vp(0), vpw(1, 0, 1, 12, 8'h30));
        rdchk("R8 locked fields masked", a_vp(0), 32'hC085_0020);
        wr(a_vp(0), vpw(0, 0, 1, 12, 8'h30));
        rdchk("R8 locked fields unmasked", a_vp(0), 32'h4085_0020);
        rdchk("R8 old vector delivered", A_IACK, 32'h20);
        wr(A_EOI, 0);
        irq_src[0] = 1'b0;
        waitc(3);
        wr(a_vp(0), vpw(0, 0, 1, 12, 8'h30));
        rdchk("R8 idle write applies", a_vp(0), 32'h008C_0030);
    endtask

    task automatic t_spurious;
        wr(A_SPUR, 32'h3C);
        rdchk("R6 programmed spurious", A_IACK, 32'h3C);
    endtask

    task automatic t_soft_reset;
        wr(A_GCFG, 32'h8000_0000);
        rdchk("R9 reset bit cleared", A_GCFG, 0);
        rdchk("R9 tpr reinit", A_TPR, 32'hF);
        rdchk("R9 spur reinit", A_SPUR, 32'hFF);
        rdchk("R9 vp reinit", a_vp(0), 32'h8000_0000);
        rdchk("R9 dest reinit", a_dest(0), 0);
        chk("R9 irq_out", 32'(irq_out), 0);
    endtask

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        irq_src = 6'b000100;
        waitc(3);
        rst_n = 1'b1;
        waitc(1);
        t_reset();
        t_feature();
        t_edge_rise();
        t_edge_fall();
        t_level();
        t_arbitration();
        t_task_priority();
        t_mask();
        t_dest();
        t_lock();
        t_spurious();
        t_soft_reset();
        done = 1;
    end

    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule